// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Datapath

This block is the execution core of a simple 32-bit processor. On every rising clock edge it fetches one fixed-length instruction word, reads up to two operands, computes a result, touches data memory if needed, writes one register, and moves the program counter. All of this happens in a single cycle. Instruction words and data words live in two separate internal word arrays. Both arrays can therefore be read in the same cycle. A preload port fills either array before the program runs.

The datapath does not decode opcodes itself. It exposes the fetched instruction word on `instr_o`. An external decoder answers combinationally on the control inputs: destination select, operand select, write-back select, register write, memory write, branch, link-jump, upper-immediate, zero-extend and the ALU operation. The datapath contains the parts needed to act on those controls:

- a dual-read, single-write register file;
- an ALU with a zero flag;
- an immediate extender whose mode is selectable;
- a fixed 16-bit left shifter for upper-immediate loads;
- next-PC logic with its own PC+4 adder.

An exception request redirects the next PC to a fixed handler address. It also cancels the current instruction's writes.

Top module: `sc_datapath`

## Requirements
- R1: A synchronous reset sets the program counter to 0x00000000 and clears every register.
- R2: When no branch, jump or exception applies, the next PC is PC+4. This value comes from an adder separate from the ALU, so it stays correct whatever ALU operation is selected.
- R3: Instruction fields sit at fixed positions: source A in bits 25..21, source B in bits 20..16, destination in bits 15..11, immediate in bits 15..0 and jump index in bits 25..0. With destination select 1 the write goes to the bits 15..11 register, and with 0 it goes to the bits 20..16 register. ALU codes are 0 add, 1 subtract, 2 AND, 3 OR. Operand select 0 takes source B, and 1 takes the extended immediate.
- R4: ALU code 4 produces 1 when source A is less than the second operand in signed comparison, and 0 otherwise.
- R5: With zero-extend low, the 16-bit immediate is sign-extended, so 0xFFFF becomes 0xFFFFFFFF. With zero-extend high it is zero-extended, so 0xFFFF becomes 0x0000FFFF.
- R6: The upper-immediate control writes the immediate shifted left by 16, with the low half zero.
- R7: A store writes source B to data memory at the ALU address during its own cycle. A later load from that address, with write-back select 1, returns the stored word.
- R8: A branch is taken when subtracting source B from source A gives zero. The target is PC+4 plus the sign-extended offset shifted left by 2, and the offset may be negative.
- R9: The link-jump control loads the PC with {PC+4[31:28], index, 2'b00}. In the same cycle it writes PC+4 into register 31.
- R10: Register 0 always reads as zero, and no write to it is reported or kept.
- R11: While the exception request is high, the next PC is 0x00000080, and no register or data memory write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pl_imem_we | input | 1 | Preload write strobe for the instruction array |
| pl_dmem_we | input | 1 | Preload write strobe for the data array (wins over a store) |
| pl_addr | input | 32 | Preload byte address, word aligned |
| pl_wdata | input | 32 | Preload word |
| exc_req | input | 1 | Exception request: redirect to handler, cancel writes |
| ctl_reg_dst | input | 1 | Destination select: 1 = bits 15..11, 0 = bits 20..16 |
| ctl_alu_src | input | 1 | Second ALU operand: 0 = register, 1 = extended immediate |
| ctl_mem_to_reg | input | 1 | Write-back data: 0 = ALU, 1 = data memory |
| ctl_reg_write | input | 1 | Register write enable |
| ctl_mem_write | input | 1 | Data memory write enable |
| ctl_branch | input | 1 | Branch-on-equal instruction |
| ctl_jal | input | 1 | Jump and link to register 31 |
| ctl_lui | input | 1 | Write immediate shifted left by 16 |
| ctl_ext_zero | input | 1 | 1 = zero-extend immediate, 0 = sign-extend |
| ctl_alu_op | input | 3 | ALU operation code |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Fetched instruction word, for the decoder |
| zero_o | output | 1 | ALU result is zero |
| wb_we_o | output | 1 | Register write taking place this cycle |
| wb_idx_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Data being written |
| dm_we_o | output | 1 | Data memory store taking place this cycle |
| dm_addr_o | output | 32 | Data memory byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
The assertions check the PC rules on every cycle:

- the reset value;
- sequential increment;
- branch target arithmetic taken from the instruction word;
- the exception vector.

They also check on every cycle that an exception cancels both write kinds, that register 0 is never written and that a link-jump reports register 31 with PC+4. Only the directed scenarios can show the data results, because the datapath has no notion of correct data without a program. These results are signed less-than, the two extension modes, the shifted upper immediate, load-after-store through memory and a register left untouched by a cancelled instruction.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef logic [31:0] word_t;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  // Immediate widening: sign or zero fill chosen by the decoder.
  function automatic word_t ext_imm(input logic [15:0] imm, input logic zero_fill);
    ext_imm = zero_fill ? {16'h0000, imm} : {{16{imm[15]}}, imm};
  endfunction

  // Fixed left shift by 16 for upper-immediate loads.
  function automatic word_t upper_imm(input logic [15:0] imm);
    upper_imm = {imm, 16'h0000};
  endfunction

  // Branch destination: sequential address plus word offset.
  function automatic word_t branch_dest(input word_t seq, input logic [15:0] off);
    branch_dest = seq + {{14{off[15]}}, off, 2'b00};
  endfunction

  // Jump destination: region bits of the sequential address plus index.
  function automatic word_t jump_dest(input word_t seq, input logic [25:0] idx);
    jump_dest = {seq[31:28], idx, 2'b00};
  endfunction

  function automatic word_t alu_eval(input alu_op_e op, input word_t a, input word_t b);
    case (op)
      ALU_ADD: alu_eval = a + b;
      ALU_SUB: alu_eval = a - b;
      ALU_AND: alu_eval = a & b;
      ALU_OR:  alu_eval = a | b;
      ALU_SLT: alu_eval = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: alu_eval = '0;
    endcase
  endfunction

endpackage

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        we,
  input  logic [31:0] waddr,
  input  logic [31:0] wdata,
  input  logic [31:0] raddr,
  output logic [31:0] rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0] mem [DEPTH];

  // An address is usable when word aligned and inside the array.
  function automatic logic addr_ok(input logic [31:0] a);
    addr_ok = (a[1:0] == 2'b00) && (a[31:AW+2] == '0);
  endfunction

  always_ff @(posedge clk) begin
    if (we && addr_ok(waddr)) mem[waddr[AW+1:2]] <= wdata;
  end

  assign rdata = addr_ok(raddr) ? mem[raddr[AW+1:2]] : '0;
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [31:0]             wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [31:0]             rd1,
  output logic [31:0]             rd2
);
  logic [31:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  word_t   a,
  input  word_t   b,
  input  alu_op_e op,
  output word_t   y,
  output logic    zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc
  import sc_pkg::*;
#(
  parameter logic [31:0] EXC_VEC = 32'h0000_0080
) (
  input  word_t       pc,
  input  logic [15:0] off,
  input  logic [25:0] jidx,
  input  logic        branch,
  input  logic        zero,
  input  logic        jal,
  input  logic        exc,
  output word_t       pc_plus4,
  output word_t       next_pc,
  output logic        br_taken
);
  // Dedicated sequential adder, independent of the ALU.
  assign pc_plus4 = pc + 32'd4;
  assign br_taken = branch && zero;

  always_comb begin
    if (exc)           next_pc = EXC_VEC;
    else if (jal)      next_pc = jump_dest(pc_plus4, jidx);
    else if (br_taken) next_pc = branch_dest(pc_plus4, off);
    else               next_pc = pc_plus4;
  end
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int          IMEM_WORDS = 64,
  parameter int          DMEM_WORDS = 64,
  parameter int          NREG       = 32,
  parameter logic [31:0] EXC_VEC    = 32'h0000_0080
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pl_imem_we,
  input  logic        pl_dmem_we,
  input  logic [31:0] pl_addr,
  input  logic [31:0] pl_wdata,
  input  logic        exc_req,
  input  logic        ctl_reg_dst,
  input  logic        ctl_alu_src,
  input  logic        ctl_mem_to_reg,
  input  logic        ctl_reg_write,
  input  logic        ctl_mem_write,
  input  logic        ctl_branch,
  input  logic        ctl_jal,
  input  logic        ctl_lui,
  input  logic        ctl_ext_zero,
  input  logic [2:0]  ctl_alu_op,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        zero_o,
  output logic        wb_we_o,
  output logic [4:0]  wb_idx_o,
  output logic [31:0] wb_data_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);
  localparam int          RW     = $clog2(NREG);
  localparam logic [4:0]  RA_IDX = 5'(NREG - 1);

  word_t pc_q, next_pc, pc_plus4;
  word_t instr, rs_val, rt_val, imm_ext, alu_b, alu_y, dm_rdata;
  logic  br_taken;

  logic [4:0]  f_rs, f_rt, f_rd;
  logic [15:0] f_imm;
  logic [25:0] f_jidx;

  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign f_imm  = instr[15:0];
  assign f_jidx = instr[25:0];

  // Program counter.
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  // Instruction array: written only by the preload port.
  sc_wordmem #(.DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (pl_imem_we),
    .waddr (pl_addr),
    .wdata (pl_wdata),
    .raddr (pc_q),
    .rdata (instr)
  );

  sc_regfile #(.NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_we_o),
    .waddr (wb_idx_o[RW-1:0]),
    .wdata (wb_data_o),
    .ra1   (f_rs[RW-1:0]),
    .ra2   (f_rt[RW-1:0]),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  assign imm_ext = ext_imm(f_imm, ctl_ext_zero);
  assign alu_b   = ctl_alu_src ? imm_ext : rt_val;

  sc_alu u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op_e'(ctl_alu_op)),
    .y    (alu_y),
    .zero (zero_o)
  );

  // Data array: preload takes the write port over a store.
  logic        dm_port_we;
  logic [31:0] dm_port_addr, dm_port_wdata;

  assign dm_we_o       = ctl_mem_write && !exc_req;
  assign dm_port_we    = pl_dmem_we || dm_we_o;
  assign dm_port_addr  = pl_dmem_we ? pl_addr  : alu_y;
  assign dm_port_wdata = pl_dmem_we ? pl_wdata : rt_val;

  sc_wordmem #(.DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_port_we),
    .waddr (dm_port_addr),
    .wdata (dm_port_wdata),
    .raddr (alu_y),
    .rdata (dm_rdata)
  );

  sc_next_pc #(.EXC_VEC(EXC_VEC)) u_npc (
    .pc       (pc_q),
    .off      (f_imm),
    .jidx     (f_jidx),
    .branch   (ctl_branch),
    .zero     (zero_o),
    .jal      (ctl_jal),
    .exc      (exc_req),
    .pc_plus4 (pc_plus4),
    .next_pc  (next_pc),
    .br_taken (br_taken)
  );

  // Write-back selection: link, then upper immediate, then memory or ALU.
  always_comb begin
    if (ctl_jal)             wb_idx_o = RA_IDX;
    else if (ctl_reg_dst)    wb_idx_o = f_rd;
    else                     wb_idx_o = f_rt;

    if (ctl_jal)             wb_data_o = pc_plus4;
    else if (ctl_lui)        wb_data_o = upper_imm(f_imm);
    else if (ctl_mem_to_reg) wb_data_o = dm_rdata;
    else                     wb_data_o = alu_y;
  end

  assign wb_we_o    = (ctl_reg_write || ctl_jal) && !exc_req && (wb_idx_o != 5'd0);
  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

endmodule

// File: rtl/sc_datapath_chk.sv
module sc_datapath_chk #(
  parameter logic [31:0] EXC_VEC = 32'h0000_0080
) (
  input logic        clk,
  input logic        rst,
  input logic        exc_req,
  input logic        ctl_jal,
  input logic        br_taken,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wb_we,
  input logic [4:0]  wb_idx,
  input logic [31:0] wb_data,
  input logic        dm_we
);
  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc == 32'h0)); // R1

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && !ctl_jal && !br_taken) |=> (pc == $past(pc) + 32'd4)); // R2

  AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !exc_req) |=>
      (pc == $past(pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00}))); // R8

  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ctl_jal && !exc_req) |-> (wb_we && wb_idx == 5'd31 && wb_data == pc + 32'd4)); // R9

  AST_R0_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> (wb_idx != 5'd0)); // R10

  AST_EXC_VECTOR: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (pc == EXC_VEC)); // R11

  AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (!wb_we && !dm_we)); // R11
endmodule

bind sc_datapath sc_datapath_chk #(.EXC_VEC(EXC_VEC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .exc_req  (exc_req),
  .ctl_jal  (ctl_jal),
  .br_taken (br_taken),
  .pc       (pc_o),
  .instr    (instr_o),
  .wb_we    (wb_we_o),
  .wb_idx   (wb_idx_o),
  .wb_data  (wb_data_o),
  .dm_we    (dm_we_o)
);

// File: tb/sc_datapath_tb.sv
module sc_datapath_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pl_imem_we = 1'b0, pl_dmem_we = 1'b0;
  logic [31:0] pl_addr = '0, pl_wdata = '0;
  logic        exc_req = 1'b0;
  logic        c_reg_dst, c_alu_src, c_mem_to_reg, c_reg_write, c_mem_write;
  logic        c_branch, c_jal, c_lui, c_ext_zero;
  logic [2:0]  c_alu_op;
  logic [31:0] pc_o, instr_o, wb_data_o, dm_addr_o, dm_wdata_o;
  logic        zero_o, wb_we_o, dm_we_o;
  logic [4:0]  wb_idx_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_datapath u_dut (
    .clk(clk), .rst(rst), .pl_imem_we(pl_imem_we), .pl_dmem_we(pl_dmem_we),
    .pl_addr(pl_addr), .pl_wdata(pl_wdata), .exc_req(exc_req),
    .ctl_reg_dst(c_reg_dst), .ctl_alu_src(c_alu_src), .ctl_mem_to_reg(c_mem_to_reg),
    .ctl_reg_write(c_reg_write), .ctl_mem_write(c_mem_write), .ctl_branch(c_branch),
    .ctl_jal(c_jal), .ctl_lui(c_lui), .ctl_ext_zero(c_ext_zero), .ctl_alu_op(c_alu_op),
    .pc_o(pc_o), .instr_o(instr_o), .zero_o(zero_o), .wb_we_o(wb_we_o),
    .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  // Bench-side decoder; its opcode choices are private to the bench.
  localparam logic [5:0] OP_R = 6'h00, OP_ADDI = 6'h08, OP_ORI = 6'h0D, OP_LUI = 6'h0F;
  localparam logic [5:0] OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04, OP_JAL = 6'h03;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25, F_SLT = 6'h2A;

  always_comb begin
    {c_reg_dst, c_alu_src, c_mem_to_reg, c_reg_write, c_mem_write} = '0;
    {c_branch, c_jal, c_lui, c_ext_zero} = '0;
    c_alu_op = 3'd0;
    case (instr_o[31:26])
      OP_R: begin
        c_reg_dst = 1'b1;
        c_reg_write = 1'b1;
        case (instr_o[5:0])
          F_ADD:   c_alu_op = 3'd0;
          F_SUB:   c_alu_op = 3'd1;
          F_AND:   c_alu_op = 3'd2;
          F_OR:    c_alu_op = 3'd3;
          F_SLT:   c_alu_op = 3'd4;
          default: c_reg_write = 1'b0;
        endcase
      end
      OP_ADDI: begin c_alu_src = 1'b1; c_reg_write = 1'b1; end
      OP_ORI:  begin c_alu_src = 1'b1; c_reg_write = 1'b1; c_ext_zero = 1'b1; c_alu_op = 3'd3; end
      OP_LUI:  begin c_lui = 1'b1; c_reg_write = 1'b1; end
      OP_LW:   begin c_alu_src = 1'b1; c_reg_write = 1'b1; c_mem_to_reg = 1'b1; end
      OP_SW:   begin c_alu_src = 1'b1; c_mem_write = 1'b1; end
      OP_BEQ:  begin c_branch = 1'b1; c_alu_op = 3'd1; end
      OP_JAL:  c_jal = 1'b1;
      default: ;
    endcase
  end

  function automatic logic [31:0] r_ins(input int rs, input int rt, input int rd, input logic [5:0] fn);
    r_ins = {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    i_ins = {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  task automatic chk_wb(input string req, input int idx, input logic [31:0] data);
    chk_eq(req, "write enable", {31'd0, wb_we_o}, 32'd1);
    chk_eq(req, "write index", {27'd0, wb_idx_o}, 32'(idx));
    chk_eq(req, "write data", wb_data_o, data);
  endtask

  task automatic put_imem(input logic [31:0] a, input logic [31:0] w);
    pl_imem_we = 1'b1; pl_addr = a; pl_wdata = w;
    @(posedge clk); #1;
    pl_imem_we = 1'b0;
  endtask

  task automatic put_dmem(input logic [31:0] a, input logic [31:0] w);
    pl_dmem_we = 1'b1; pl_addr = a; pl_wdata = w;
    @(posedge clk); #1;
    pl_dmem_we = 1'b0;
  endtask

  // Hold reset and fill the instruction array with no-write words.
  task automatic begin_prog();
    rst = 1'b1; exc_req = 1'b0;
    for (int i = 0; i < 64; i++) put_imem(32'(i * 4), 32'h0);
  endtask

  // Leave reset; then sample the first instruction at the falling edge.
  task automatic start_prog();
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic next_instr();
    @(negedge clk);
  endtask

  task automatic t_reset();
    begin_prog();
    put_imem(32'h0, r_ins(1, 2, 3, F_ADD));
    start_prog();
    chk_eq("R1", "pc after reset", pc_o, 32'h0);
    chk_wb("R1", 3, 32'h0);
    next_instr();
    chk_eq("R2", "pc increments by 4", pc_o, 32'h4);
  endtask

  task automatic t_arith();
    begin_prog();
    put_imem(32'h00, i_ins(OP_ADDI, 0, 1, 16'd5));
    put_imem(32'h04, i_ins(OP_ADDI, 0, 2, 16'hFFFD));
    put_imem(32'h08, r_ins(1, 2, 3, F_ADD));
    put_imem(32'h0C, r_ins(1, 2, 4, F_SUB));
    put_imem(32'h10, r_ins(1, 2, 5, F_AND));
    put_imem(32'h14, r_ins(2, 1, 6, F_OR));
    put_imem(32'h18, r_ins(2, 1, 7, F_SLT));
    put_imem(32'h1C, r_ins(1, 2, 8, F_SLT));
    start_prog();
    chk_wb("R3", 1, 32'd5);                 next_instr();
    chk_wb("R5", 2, 32'hFFFF_FFFD);         next_instr();
    chk_wb("R3", 3, 32'd2);                 next_instr();
    chk_wb("R3", 4, 32'd8);                 next_instr();
    chk_wb("R3", 5, 32'd5);                 next_instr();
    chk_wb("R3", 6, 32'hFFFF_FFFD);         next_instr();
    chk_wb("R4", 7, 32'd1);                 next_instr();
    chk_wb("R4", 8, 32'd0);
    chk_eq("R2", "pc after sequence", pc_o, 32'h1C);
  endtask

  task automatic t_extend();
    begin_prog();
    put_imem(32'h00, i_ins(OP_ADDI, 0, 1, 16'hFFFF));
    put_imem(32'h04, i_ins(OP_ORI, 0, 2, 16'hFFFF));
    put_imem(32'h08, i_ins(OP_LUI, 0, 3, 16'h1234));
    start_prog();
    chk_wb("R5", 1, 32'hFFFF_FFFF);  next_instr();
    chk_wb("R5", 2, 32'h0000_FFFF);  next_instr();
    chk_wb("R6", 3, 32'h1234_0000);
  endtask

  task automatic t_memory();
    begin_prog();
    put_dmem(32'h10, 32'hCAFE_F00D);
    put_imem(32'h00, i_ins(OP_LW, 0, 1, 16'h0010));
    put_imem(32'h04, i_ins(OP_SW, 0, 1, 16'h0020));
    put_imem(32'h08, i_ins(OP_LW, 0, 2, 16'h0020));
    start_prog();
    chk_wb("R7", 1, 32'hCAFE_F00D);  next_instr();
    chk_eq("R7", "store strobe", {31'd0, dm_we_o}, 32'd1);
    chk_eq("R7", "store address", dm_addr_o, 32'h20);
    chk_eq("R7", "store data", dm_wdata_o, 32'hCAFE_F00D);
    next_instr();
    chk_wb("R7", 2, 32'hCAFE_F00D);
  endtask

  task automatic t_zero_reg();
    begin_prog();
    put_imem(32'h00, i_ins(OP_ADDI, 0, 0, 16'd7));
    put_imem(32'h04, r_ins(0, 0, 1, F_ADD));
    start_prog();
    chk_eq("R10", "write to r0 suppressed", {31'd0, wb_we_o}, 32'd0);
    next_instr();
    chk_wb("R10", 1, 32'd0);
  endtask

  task automatic t_branch();
    begin_prog();
    put_imem(32'h00, i_ins(OP_ADDI, 0, 1, 16'd3));
    put_imem(32'h04, i_ins(OP_ADDI, 0, 2, 16'd3));
    put_imem(32'h08, i_ins(OP_BEQ, 1, 2, 16'd2));
    put_imem(32'h14, i_ins(OP_BEQ, 1, 0, 16'd5));
    put_imem(32'h18, i_ins(OP_BEQ, 0, 0, 16'hFFFA));
    start_prog();
    next_instr(); next_instr();
    chk_eq("R8", "zero flag on equal", {31'd0, zero_o}, 32'd1);
    next_instr();
    chk_eq("R8", "taken branch target", pc_o, 32'h14);
    next_instr();
    chk_eq("R8", "untaken branch falls through", pc_o, 32'h18);
    next_instr();
    chk_eq("R8", "negative offset target", pc_o, 32'h4);
  endtask

  task automatic t_jal();
    begin_prog();
    put_imem(32'h00, {OP_JAL, 26'h10});
    put_imem(32'h40, r_ins(31, 0, 1, F_ADD));
    start_prog();
    chk_wb("R9", 31, 32'h4);
    next_instr();
    chk_eq("R9", "jump target", pc_o, 32'h40);
    chk_wb("R9", 1, 32'h4);
  endtask

  task automatic t_exception();
    begin_prog();
    put_imem(32'h00, i_ins(OP_ADDI, 0, 1, 16'd9));
    put_imem(32'h80, r_ins(1, 0, 2, F_ADD));
    put_imem(32'h84, i_ins(OP_SW, 0, 0, 16'h0030));
    exc_req = 1'b1;
    start_prog();
    chk_eq("R11", "write cancelled", {31'd0, wb_we_o}, 32'd0);
    @(posedge clk); #1;
    exc_req = 1'b0;
    @(negedge clk);
    chk_eq("R11", "handler address", pc_o, 32'h80);
    chk_wb("R11", 2, 32'h0);
    @(posedge clk); #1;
    exc_req = 1'b1;
    @(negedge clk);
    chk_eq("R11", "store cancelled", {31'd0, dm_we_o}, 32'd0);
    @(posedge clk); #1;
    exc_req = 1'b0;
    @(negedge clk);
    chk_eq("R11", "handler re-entered", pc_o, 32'h80);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_arith();
    t_extend();
    t_memory();
    t_zero_reg();
    t_branch();
    t_jal();
    t_exception();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      summary();
    end
  end
endmodule